// File: doc/BRIEF.md
# Block-Transfer DMA Engine with Chained Bus Grant

This block moves a block of words between a device-side streaming port and memory without processor involvement. Software loads a start address and a word count, then writes a status/control word that chooses the direction, the interrupt enable and the bus-holding mode, and sets the start bit. The engine then asks the processor for the bus, moves the words one per clock while it owns the bus, and raises DONE (and an interrupt if enabled) when the count reaches zero.

The bus grant reaches the engine on a daisy chain. An idle engine passes the incoming grant straight on to the next controller. An engine that is requesting or owning the bus holds the grant back and signals bus-busy while it drives memory. In burst mode the bus is held for the whole block. In cycle-stealing mode the bus is released after every word and requested again for the next one.

The memory and the device are outside the block. Memory answers reads in the same cycle and takes writes at the clock edge. The device always accepts a push and always has a word ready for a pop.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset, all three registers read 0. `cfg_sel` selects the register that `cfg_rdata` shows: 0 is the current address, 1 is the remaining word count, and 2 is status. Status bits are DONE=bit0, DIR=bit1, IE=bit2 and BURST=bit3, and all other bits read 0. Any status write clears DONE.
- R2: A status write with bit7 set and a nonzero count starts a transfer. `bus_req` is high in the cycle after that write.
- R3: A start with a count of 0 sets DONE at once and never raises `bus_req` or `bus_busy`.
- R4: While the engine neither requests nor owns the bus, `grant_out` equals `grant_in`. While `bus_req` or `bus_busy` is high, `grant_out` is 0.
- R5: `bus_busy` rises only after a cycle in which both `bus_req` and `grant_in` were high. `bus_req` and `bus_busy` are never high together.
- R6: With DIR=1, each owned cycle pops one device word and writes it to memory at the current address. The address rises by 1 per word.
- R7: With DIR=0, each owned cycle reads memory at the current address and pushes that word to the device. The address rises by 1 per word.
- R8: With BURST=1, `bus_busy` rises once and stays high for exactly N cycles for an N-word block.
- R9: With BURST=0, `bus_busy` lasts one cycle per word and drops after each word, so an N-word block shows N separate busy pulses.
- R10: After the last word, DONE is 1, the count reads 0, the address reads start+N, and both bus signals are low.
- R11: `irq` is high exactly when DONE and IE are both 1. It is low whenever the engine requests or owns the bus.
- R12: Register writes are ignored while a transfer is pending or running.
- R13: While `grant_in` stays low, the engine keeps `bus_req` high and makes no memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 address, 1 count, 2 status) |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Selected register contents |
| bus_req | output | 1 | Bus request to the processor |
| grant_in | input | 1 | Bus grant arriving on the chain |
| grant_out | output | 1 | Bus grant passed to the next controller |
| bus_busy | output | 1 | Bus held by this engine |
| mem_valid | output | 1 | Memory cycle this clock |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| dev_rd | output | 1 | Pop one word from the device |
| dev_rdata | input | DW | Device word at the head |
| dev_wr | output | 1 | Push one word to the device |
| dev_wdata | output | DW | Word pushed to the device |
| irq | output | 1 | Completion interrupt |

## Verification
A start write takes effect at one clock edge, and `bus_req` is visible in the cycle after that edge. With the grant already present, the first owned cycle follows one cycle later. Each owned cycle carries its memory access, and the address and count change at the end of that cycle. DONE and `irq` appear in the cycle after the last owned cycle. The bench drives inputs just after a rising edge and samples at the falling edge. A scoreboard compares every memory cycle, in order, against the items the driver queued. Busy-pulse and busy-cycle counts confirm the burst and cycle-stealing shapes, and the registers are read back only once DONE has been seen.

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          bus_req,
  input  logic          grant_in,
  output logic          grant_out,
  output logic          bus_busy,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          dev_rd,
  input  logic [DW-1:0] dev_rdata,
  output logic          dev_wr,
  output logic [DW-1:0] dev_wdata,
  output logic          irq
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER} st_t;

  st_t           state;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] words;
  logic          done, dir, ie, burst;

  wire idle = (state == S_IDLE);
  wire own  = (state == S_XFER);

  assign bus_req   = (state == S_REQ);
  assign bus_busy  = own;
  assign grant_out = grant_in & idle;
  assign irq       = done & ie;

  assign mem_valid = own;
  assign mem_we    = own & dir;
  assign mem_addr  = cur_addr;
  assign mem_wdata = dev_rdata;
  assign dev_rd    = own & dir;
  assign dev_wr    = own & ~dir;
  assign dev_wdata = mem_rdata;

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = DW'(cur_addr);
      2'd1:    cfg_rdata = DW'(words);
      2'd2:    cfg_rdata = DW'({burst, ie, dir, done});
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_addr <= '0;
      words    <= '0;
      done     <= 1'b0;
      dir      <= 1'b0;
      ie       <= 1'b0;
      burst    <= 1'b0;
    end else begin
      if (cfg_we && idle) begin
        case (cfg_sel)
          2'd0: cur_addr <= cfg_wdata[AW-1:0];
          2'd1: words    <= cfg_wdata[CW-1:0];
          2'd2: begin
            dir   <= cfg_wdata[1];
            ie    <= cfg_wdata[2];
            burst <= cfg_wdata[3];
            done  <= cfg_wdata[7] && (words == '0);
            if (cfg_wdata[7] && (words != '0)) state <= S_REQ;
          end
          default: ;
        endcase
      end
      case (state)
        S_REQ:  if (grant_in) state <= S_XFER;
        S_XFER: begin
          cur_addr <= cur_addr + 1'b1;
          words    <= words - 1'b1;
          if (words == CW'(1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else if (!burst) begin
            state <= S_REQ;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dma_chain_ctrl_chk.sv
module dma_chain_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req,
  input logic grant_in,
  input logic grant_out,
  input logic bus_busy,
  input logic irq,
  input logic done,
  input logic burst
);

  p_grant_before_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> ($past(bus_req) && $past(grant_in)));

  p_req_busy_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_busy));

  p_grant_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || bus_busy) |-> !grant_out);

  p_grant_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && !bus_busy) |-> (grant_out == grant_in));

  p_steal_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !burst) |=> !bus_busy);

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!bus_req && !bus_busy));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_req && !bus_busy));

endmodule

bind dma_chain_ctrl dma_chain_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .grant_in(grant_in),
  .grant_out(grant_out), .bus_busy(bus_busy), .irq(irq),
  .done(done), .burst(burst)
);

// File: tb/dma_chain_ctrl_test.sv
module dma_chain_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic        bus_req, grant_in = 0, grant_out, bus_busy;
  logic        mem_valid, mem_we, dev_rd, dev_wr, irq;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, dev_rdata, dev_wdata;

  always #2 clk = ~clk;

  dma_chain_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
    .grant_in(grant_in), .grant_out(grant_out), .bus_busy(bus_busy),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_rd(dev_rd),
    .dev_rdata(dev_rdata), .dev_wr(dev_wr), .dev_wdata(dev_wdata), .irq(irq)
  );

  int total = 0, bad = 0;
  int busy_cyc = 0, rises = 0;
  logic prev_busy = 0;

  logic [15:0] mem [0:255];
  logic [15:0] src [0:31];
  int sidx = 0;
  logic [32:0] expq[$];

  assign mem_rdata = mem[mem_addr[7:0]];
  assign dev_rdata = src[sidx[4:0]];

  always @(posedge clk) begin
    if (mem_valid && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (dev_rd) sidx <= sidx + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_busy) busy_cyc++;
      if (bus_busy && !prev_busy) rises++;
      prev_busy = bus_busy;
      if (mem_valid) begin
        if (expq.size() == 0) begin
          chk("R6 unexpected memory cycle", 32'(mem_addr), 32'hFFFF_FFFF);
        end else begin
          logic [32:0] e;
          e = expq.pop_front();
          chk(e[32] ? "R6 direction" : "R7 direction", 32'(mem_we), 32'(e[32]));
          chk(e[32] ? "R6 address" : "R7 address", 32'(mem_addr), 32'(e[31:16]));
          if (e[32]) chk("R6 data", 32'(mem_wdata), 32'(e[15:0]));
          else begin
            chk("R7 push", 32'(dev_wr), 32'd1);
            chk("R7 data", 32'(dev_wdata), 32'(e[15:0]));
          end
        end
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] d);
    cfg_sel = s;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic plan_run(input logic dir, input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      if (dir) expq.push_back({1'b1, 16'(a + 16'(i)), src[5'(sidx + i)]});
      else     expq.push_back({1'b0, 16'(a + 16'(i)), mem[8'(a + 16'(i))]});
    end
  endtask

  task automatic wait_done();
    logic [15:0] s;
    for (int k = 0; k < 200; k++) begin
      rd(2'd2, s);
      if (s[0]) break;
    end
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 32; i++) src[i] = 16'hA000 + 16'(i * 3);
    for (int i = 0; i < 256; i++) mem[i] = 16'h5000 + 16'(i);

    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(2'd0, v); chk("R1 reset address", 32'(v), 0);
    rd(2'd1, v); chk("R1 reset count", 32'(v), 0);
    rd(2'd2, v); chk("R1 reset status", 32'(v), 0);
    chk("R1 reset bus_req", 32'(bus_req), 0);
    chk("R1 reset irq", 32'(irq), 0);

    @(posedge clk); #1 grant_in = 1;
    @(negedge clk); chk("R4 pass grant high", 32'(grant_out), 1);
    @(posedge clk); #1 grant_in = 0;
    @(negedge clk); chk("R4 pass grant low", 32'(grant_out), 0);

    // burst, device to memory, interrupt enabled
    grant_in = 1;
    wr(2'd0, 16'h0040);
    wr(2'd1, 16'd4);
    plan_run(1'b1, 16'h0040, 4);
    busy_cyc = 0; rises = 0;
    wr(2'd2, 16'h008E);
    @(negedge clk);
    chk("R2 request after start", 32'(bus_req), 1);
    chk("R4 grant blocked", 32'(grant_out), 0);
    wait_done();
    chk("R8 busy cycles", 32'(busy_cyc), 4);
    chk("R8 single busy pulse", 32'(rises), 1);
    rd(2'd0, v); chk("R10 end address", 32'(v), 32'h44);
    rd(2'd1, v); chk("R10 end count", 32'(v), 0);
    chk("R10 bus released", 32'(bus_busy | bus_req), 0);
    chk("R11 irq raised", 32'(irq), 1);
    chk("R6 memory contents", 32'(mem[8'h43]), 32'(src[3]));
    wr(2'd2, 16'h0004);
    rd(2'd2, v); chk("R1 status write clears DONE", 32'(v), 32'h4);
    chk("R11 irq cleared", 32'(irq), 0);

    // cycle stealing, memory to device, no interrupt
    wr(2'd0, 16'h0080);
    wr(2'd1, 16'd3);
    plan_run(1'b0, 16'h0080, 3);
    busy_cyc = 0; rises = 0;
    wr(2'd2, 16'h0080);
    wait_done();
    chk("R9 busy cycles", 32'(busy_cyc), 3);
    chk("R9 busy pulses", 32'(rises), 3);
    rd(2'd2, v); chk("R10 done status", 32'(v), 32'h1);
    chk("R11 irq masked", 32'(irq), 0);
    rd(2'd0, v); chk("R10 steal end address", 32'(v), 32'h83);

    // zero count
    wr(2'd1, 16'd0);
    busy_cyc = 0;
    wr(2'd2, 16'h0084);
    @(negedge clk);
    chk("R3 no request", 32'(bus_req), 0);
    rd(2'd2, v); chk("R3 done at once", 32'(v), 32'h5);
    chk("R3 no busy", 32'(busy_cyc), 0);

    // grant withheld, writes while pending
    grant_in = 0;
    wr(2'd0, 16'h0010);
    wr(2'd1, 16'd2);
    plan_run(1'b1, 16'h0010, 2);
    wr(2'd2, 16'h008A);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R13 request held", 32'(bus_req), 1);
    chk("R13 no ownership", 32'(bus_busy), 0);
    wr(2'd1, 16'd7);
    wr(2'd0, 16'h0099);
    rd(2'd1, v); chk("R12 count write ignored", 32'(v), 2);
    rd(2'd0, v); chk("R12 address write ignored", 32'(v), 32'h10);
    @(posedge clk); #1 grant_in = 1;
    wait_done();
    rd(2'd0, v); chk("R10 late grant end address", 32'(v), 32'h12);
    chk("R6 all items seen", 32'(expq.size()), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule